// File: doc/BRIEF.md
# Adaptive Per-Pixel Exposure Scheduler

This block decides, pixel by pixel and at run time, how long each pixel of a random-access imager integrates. The sensor supports nondestructive reads, so the scheduler can look at a pixel as often as it likes while the charge keeps building. It walks a list of pixels in a fixed number of passes. For each pixel it issues a read request and waits for the digitized 16-bit sample that comes back with the pixel's index. If the sample has reached the programmed threshold, the scheduler adds it to that pixel's 32-bit bank, counts one completed short cycle, and asks the sensor to dump the pixel's charge so that integration starts again. A sample below the threshold is only kept as the pixel's residual. Bright pixels therefore end up as a sum of many short exposures, and dim pixels as one long exposure.

A separate command clears a contiguous range of pixel indices, both in the block's own storage and, through a forwarded clear request, on the sensor. This keeps intense sources from swamping weak signals elsewhere. After the last pass the block raises a one-cycle done pulse. It then streams one result per pixel in ascending index order under valid/ready flow control. Each result carries the banked sum plus the residual, and the number of banked cycles.

Top module: `rai_sched_top`

## Requirements
- R1: After reset, read_req_valid, inject_valid, clr_req_valid, done and res_valid are all low, and the block waits for start.
- R2: A start pulse seen while idle latches cfg_threshold and cfg_passes, where a pass count of 0 runs as 1 pass. Changes to either input after start have no effect on the frame. A start pulse during a frame is ignored.
- R3: Each pass issues one single-cycle read request per pixel, with indices 0 up to NPIX-1 in ascending order. The next request is issued only after the sample for the current one has been taken, so a frame makes exactly NPIX times the latched pass count of requests.
- R4: A sample is taken only while a request is outstanding and sample_idx equals the requested index. Any other sample changes no state and raises no inject.
- R5: A taken sample whose value is greater than or equal to the threshold raises inject_valid with inject_idx equal to the pixel, in the same cycle as the sample. The value is added to the pixel's bank, its cycle count rises by one, and its residual becomes 0.
- R6: A taken sample below the threshold raises no inject and replaces the pixel's residual. The bank and the cycle count keep their values.
- R7: A clear command zeroes the bank, cycle count and residual of every pixel with an index in roi_lo..roi_hi inclusive. A range with lo greater than hi clears nothing. The clear wins over a sample taken for the same pixel in the same cycle. In the next cycle clr_req_valid is high, with the command's lo and hi.
- R8: In the cycle after the final sample of the last pass is taken, done is high for exactly one cycle. Results then stream for indices 0 to NPIX-1 in order, each with res_total equal to the bank plus the residual (modulo 2^32) and res_cycles equal to the cycle count.
- R9: While res_valid is high and res_ready is low, res_valid stays high and res_idx holds its value.
- R10: A start taken while idle zeroes the bank, cycle count and residual of every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| cfg_threshold | input | 16 | Banking threshold |
| cfg_passes | input | 8 | Passes per frame (0 runs as 1) |
| sample_valid | input | 1 | Sample strobe from the digitizer |
| sample_idx | input | 3 | Pixel index of the sample |
| sample_data | input | 16 | Digitized nondestructive read |
| roi_valid | input | 1 | Region clear command |
| roi_lo | input | 3 | First index to clear |
| roi_hi | input | 3 | Last index to clear |
| read_req_valid | output | 1 | Nondestructive read request |
| read_req_idx | output | 3 | Pixel to read |
| inject_valid | output | 1 | Dump charge of a banked pixel |
| inject_idx | output | 3 | Pixel to dump |
| clr_req_valid | output | 1 | Forwarded region clear |
| clr_req_lo | output | 3 | Forwarded first index |
| clr_req_hi | output | 3 | Forwarded last index |
| done | output | 1 | One-cycle end-of-frame pulse |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result accepted |
| res_idx | output | 3 | Pixel of the result |
| res_total | output | 32 | Bank plus residual |
| res_cycles | output | 16 | Number of banked short cycles |

## Verification
A wrong banking decision shows at the port at once: inject_valid is wrong in the very cycle of the sample. The damage to the bank stays hidden until the frame ends, when res_total and res_cycles for that pixel differ. A pass or pixel pointer that slips shows on the next read request as an out-of-order index, or later as a frame with the wrong number of requests and a late or early done. A missed clear is visible one cycle later on clr_req_valid, and in the streamed totals at the end of the frame. The bench therefore checks every inject against the sample it follows, and compares every streamed result with a sensor-and-bank model of its own.

// File: rtl/rai_pkg.sv
package rai_pkg;
  localparam int SMP_W = 16;
  localparam int ACC_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} rai_state_e;

  // A peek at or above the threshold is banked.
  function automatic logic reaches_limit(input logic [SMP_W-1:0] v,
                                         input logic [SMP_W-1:0] lim);
    return v >= lim;
  endfunction

  // Final result: banked sum plus last residual, wrapping at ACC_W bits.
  function automatic logic [ACC_W-1:0] final_total(input logic [ACC_W-1:0] bank,
                                                   input logic [SMP_W-1:0] resid);
    return bank + ACC_W'(resid);
  endfunction
endpackage

// File: rtl/rai_sequencer.sv
module rai_sequencer
  import rai_pkg::*;
#(
  parameter int NPIX   = 8,
  parameter int PASS_W = 8,
  parameter int IDX_W  = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic              sample_valid,
  input  logic [IDX_W-1:0]  sample_idx,
  input  logic              res_ready,
  output logic              frame_start,
  output logic              take,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              read_req_valid,
  output logic              done,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  rai_state_e        state;
  logic [IDX_W-1:0]  ptr, optr;
  logic [PASS_W-1:0] pass, passes_q;
  logic              done_q;
  logic              last_pix, last_pass;

  assign frame_start    = (state == ST_IDLE) && start;
  assign take           = (state == ST_WAIT) && sample_valid && (sample_idx == ptr);
  assign last_pix       = (ptr == LAST_IDX);
  assign last_pass      = (pass == passes_q - 1'b1);
  assign cur_idx        = ptr;
  assign read_req_valid = (state == ST_REQ);
  assign done           = done_q;
  assign res_valid      = (state == ST_OUT);
  assign res_idx        = optr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ptr      <= '0;
      optr     <= '0;
      pass     <= '0;
      passes_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          passes_q <= (cfg_passes == '0) ? PASS_W'(1) : cfg_passes;
          ptr      <= '0;
          pass     <= '0;
          state    <= ST_REQ;
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: if (take) begin
          if (last_pix) begin
            ptr <= '0;
            if (last_pass) begin
              state  <= ST_OUT;
              optr   <= '0;
              done_q <= 1'b1;
            end else begin
              pass  <= pass + 1'b1;
              state <= ST_REQ;
            end
          end else begin
            ptr   <= ptr + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_OUT: if (res_ready) begin
          if (optr == LAST_IDX) state <= ST_IDLE;
          else optr <= optr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_req_valid |=> !read_req_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid && (res_idx == '0));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_idx)));
endmodule

// File: rtl/rai_pixel_bank.sv
module rai_pixel_bank
  import rai_pkg::*;
#(
  parameter int NPIX  = 8,
  parameter int CNT_W = 16,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [SMP_W-1:0]  cfg_threshold,
  input  logic              take,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [SMP_W-1:0]  sample_data,
  input  logic              roi_valid,
  input  logic [IDX_W-1:0]  roi_lo,
  input  logic [IDX_W-1:0]  roi_hi,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              bank_fire,
  output logic [ACC_W-1:0]  rd_total,
  output logic [CNT_W-1:0]  rd_cycles
);
  logic [SMP_W-1:0] thr_q;
  logic [ACC_W-1:0] acc_a [NPIX];
  logic [CNT_W-1:0] cnt_a [NPIX];
  logic [SMP_W-1:0] res_a [NPIX];

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= '0;
    else if (frame_start) thr_q <= cfg_threshold;
  end

  assign bank_fire = take && reaches_limit(sample_data, thr_q);

  for (genvar k = 0; k < NPIX; k++) begin : g_pix
    logic hit_k, clr_k;
    assign hit_k = take && (cur_idx == IDX_W'(k));
    assign clr_k = frame_start ||
                   (roi_valid && (IDX_W'(k) >= roi_lo) && (IDX_W'(k) <= roi_hi));

    always_ff @(posedge clk) begin
      if (!rst_n || clr_k) begin
        acc_a[k] <= '0;
        cnt_a[k] <= '0;
        res_a[k] <= '0;
      end else if (hit_k) begin
        if (bank_fire) begin
          acc_a[k] <= acc_a[k] + ACC_W'(sample_data);
          cnt_a[k] <= cnt_a[k] + 1'b1;
          res_a[k] <= '0;
        end else begin
          res_a[k] <= sample_data;
        end
      end
    end

    // R7
    roi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (roi_valid && (IDX_W'(k) >= roi_lo) && (IDX_W'(k) <= roi_hi))
        |=> (acc_a[k] == '0) && (cnt_a[k] == '0) && (res_a[k] == '0));

    // R5
    bank_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_k && bank_fire && !clr_k) |=> (cnt_a[k] == $past(cnt_a[k]) + 1'b1)
                                          && (res_a[k] == '0));

    // R6
    keep_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_k && !bank_fire && !clr_k) |=> $stable(acc_a[k]) && $stable(cnt_a[k]));
  end

  always_comb begin
    rd_total  = '0;
    rd_cycles = '0;
    for (int j = 0; j < NPIX; j++) begin
      if (rd_idx == IDX_W'(j)) begin
        rd_total  = final_total(acc_a[j], res_a[j]);
        rd_cycles = cnt_a[j];
      end
    end
  end
endmodule

// File: rtl/rai_sched_top.sv
module rai_sched_top
  import rai_pkg::*;
#(
  parameter int NPIX   = 8,
  parameter int PASS_W = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SMP_W-1:0]  cfg_threshold,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic              sample_valid,
  input  logic [IDX_W-1:0]  sample_idx,
  input  logic [SMP_W-1:0]  sample_data,
  input  logic              roi_valid,
  input  logic [IDX_W-1:0]  roi_lo,
  input  logic [IDX_W-1:0]  roi_hi,
  output logic              read_req_valid,
  output logic [IDX_W-1:0]  read_req_idx,
  output logic              inject_valid,
  output logic [IDX_W-1:0]  inject_idx,
  output logic              clr_req_valid,
  output logic [IDX_W-1:0]  clr_req_lo,
  output logic [IDX_W-1:0]  clr_req_hi,
  output logic              done,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [IDX_W-1:0]  res_idx,
  output logic [ACC_W-1:0]  res_total,
  output logic [CNT_W-1:0]  res_cycles
);
  logic             frame_start, take, bank_fire;
  logic [IDX_W-1:0] cur_idx;

  rai_sequencer #(.NPIX(NPIX), .PASS_W(PASS_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_passes(cfg_passes),
    .sample_valid(sample_valid), .sample_idx(sample_idx), .res_ready(res_ready),
    .frame_start(frame_start), .take(take), .cur_idx(cur_idx),
    .read_req_valid(read_req_valid), .done(done),
    .res_valid(res_valid), .res_idx(res_idx)
  );

  rai_pixel_bank #(.NPIX(NPIX), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_threshold(cfg_threshold), .take(take), .cur_idx(cur_idx),
    .sample_data(sample_data), .roi_valid(roi_valid), .roi_lo(roi_lo),
    .roi_hi(roi_hi), .rd_idx(res_idx), .bank_fire(bank_fire),
    .rd_total(res_total), .rd_cycles(res_cycles)
  );

  assign read_req_idx = cur_idx;
  assign inject_valid = bank_fire;
  assign inject_idx   = cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_req_valid <= 1'b0;
      clr_req_lo    <= '0;
      clr_req_hi    <= '0;
    end else begin
      clr_req_valid <= roi_valid;
      clr_req_lo    <= roi_lo;
      clr_req_hi    <= roi_hi;
    end
  end

  // R7
  clr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roi_valid |=> clr_req_valid && (clr_req_lo == $past(roi_lo))
                  && (clr_req_hi == $past(roi_hi)));

  // R4
  inject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inject_valid |-> sample_valid && (sample_idx == inject_idx));

  // R3
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_req_valid |-> !res_valid && !inject_valid);
endmodule

// File: tb/rai_sched_top_test.sv
module rai_sched_top_test;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_threshold = '0;
  logic [7:0]  cfg_passes = '0;
  logic        sample_valid = 1'b0;
  logic [2:0]  sample_idx = '0;
  logic [15:0] sample_data = '0;
  logic        roi_valid = 1'b0;
  logic [2:0]  roi_lo = '0, roi_hi = '0;
  logic        read_req_valid, inject_valid, clr_req_valid, done, res_valid;
  logic [2:0]  read_req_idx, inject_idx, clr_req_lo, clr_req_hi, res_idx;
  logic        res_ready = 1'b1;
  logic [31:0] res_total;
  logic [15:0] res_cycles;

  always #2 clk = ~clk;

  rai_sched_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_threshold(cfg_threshold),
    .cfg_passes(cfg_passes), .sample_valid(sample_valid), .sample_idx(sample_idx),
    .sample_data(sample_data), .roi_valid(roi_valid), .roi_lo(roi_lo), .roi_hi(roi_hi),
    .read_req_valid(read_req_valid), .read_req_idx(read_req_idx),
    .inject_valid(inject_valid), .inject_idx(inject_idx),
    .clr_req_valid(clr_req_valid), .clr_req_lo(clr_req_lo), .clr_req_hi(clr_req_hi),
    .done(done), .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx),
    .res_total(res_total), .res_cycles(res_cycles)
  );

  typedef struct { int idx; logic [31:0] tot; logic [15:0] cyc; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_err = 0, done_cnt = 0, tick = 0;
  bit stall = 1'b0;
  int flux [NP];
  int charge [NP];
  logic [31:0] m_acc [NP];
  logic [15:0] m_cnt [NP];
  logic [15:0] m_res [NP];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: drives ready, pops expected results on each handshake.
  always @(negedge clk) begin
    tick++;
    res_ready <= stall ? tick[0] : 1'b1;
    #1;
    if (done) begin
      done_cnt++;
      chk(res_valid && res_idx == 3'd0, "R8", "stream starts with done", res_idx, 0);
    end
    if (res_valid && res_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected result", res_idx, -1);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(res_idx == 3'(e.idx), "R8", "result order", res_idx, e.idx);
        chk(res_total == e.tot, "R8", "total", res_total, e.tot);
        chk(res_cycles == e.cyc, "R8", "cycle count", res_cycles, e.cyc);
      end
    end
  end

  task automatic run_frame(input logic [15:0] thr, input logic [7:0] passes,
                           input int roi_pass, input int roi_pix,
                           input logic [2:0] lo, input logic [2:0] hi,
                           input bit bogus, input bit busy_start);
    int eff, d0;
    eff = (passes == 0) ? 1 : passes;
    d0 = done_cnt;
    for (int k = 0; k < NP; k++) begin   // R10: start zeroes all storage
      m_acc[k] = '0; m_cnt[k] = '0; m_res[k] = '0; charge[k] = 0;
    end
    @(negedge clk);
    start = 1'b1; cfg_threshold = thr; cfg_passes = passes;
    @(negedge clk);
    start = 1'b0;
    cfg_threshold = 16'd1; cfg_passes = 8'd9;   // R2: ignored after start
    for (int p = 0; p < eff; p++) begin
      for (int i = 0; i < NP; i++) begin
        bit fire, roi_now;
        logic [15:0] v;
        while (!read_req_valid) @(negedge clk);
        #1;
        chk(read_req_idx == 3'(i), "R3", "request order", read_req_idx, i);
        @(negedge clk);
        if (busy_start && p == 0 && i == 2) start = 1'b1;   // R2: ignored when busy
        if (bogus) begin   // R4: mismatched index ignored
          sample_valid = 1'b1; sample_idx = 3'(i) ^ 3'd1; sample_data = 16'hFFFF;
          #1;
          chk(!inject_valid, "R4", "inject on foreign sample", inject_valid, 0);
          @(negedge clk);
          start = 1'b0;
          chk(!read_req_valid, "R4", "foreign sample advanced", read_req_valid, 0);
        end
        start = 1'b0;
        charge[i] = (charge[i] + flux[i] > 65535) ? 65535 : charge[i] + flux[i];
        v = 16'(charge[i]);
        roi_now = (p == roi_pass) && (i == roi_pix);
        sample_valid = 1'b1; sample_idx = 3'(i); sample_data = v;
        if (roi_now) begin roi_valid = 1'b1; roi_lo = lo; roi_hi = hi; end
        #1;
        fire = (v >= thr);
        chk(inject_valid == fire, fire ? "R5" : "R6", "inject decision", inject_valid, fire);
        if (fire) chk(inject_idx == 3'(i), "R5", "inject index", inject_idx, i);
        if (fire) begin
          m_acc[i] = m_acc[i] + 32'(v); m_cnt[i] = m_cnt[i] + 1'b1;
          m_res[i] = '0; charge[i] = 0;
        end else m_res[i] = v;
        if (roi_now) begin   // R7: clear wins, inclusive range
          for (int k = 0; k < NP; k++)
            if (k >= int'(lo) && k <= int'(hi)) begin
              m_acc[k] = '0; m_cnt[k] = '0; m_res[k] = '0; charge[k] = 0;
            end
        end
        if (p == eff - 1 && i == NP - 1)
          for (int k = 0; k < NP; k++) begin
            exp_t e;
            e.idx = k; e.tot = m_acc[k] + 32'(m_res[k]); e.cyc = m_cnt[k];
            exp_q.push_back(e);
          end
        @(negedge clk);
        sample_valid = 1'b0; roi_valid = 1'b0;
        #1;
        chk(clr_req_valid == roi_now, "R7", "forwarded clear", clr_req_valid, roi_now);
        if (roi_now) begin
          chk(clr_req_lo == lo, "R7", "clear lo", clr_req_lo, lo);
          chk(clr_req_hi == hi, "R7", "clear hi", clr_req_hi, hi);
        end
      end
    end
    while (exp_q.size() != 0 || res_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    chk(done_cnt == d0 + 1, "R8", "done pulses per frame", done_cnt - d0, 1);
    chk(!read_req_valid && !res_valid, "R3", "idle after frame", read_req_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!read_req_valid && !inject_valid && !clr_req_valid && !done && !res_valid,
        "R1", "outputs in reset", read_req_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!read_req_valid && !res_valid, "R1", "idle after reset", res_valid, 0);

    // Frame 1: threshold equality, saturated pixel, dark pixel.
    flux = '{10, 500, 999, 1000, 0, 65535, 250, 300};
    run_frame(16'd1000, 8'd4, -1, 0, 3'd0, 3'd0, 1'b0, 1'b0);

    // Frame 2: region clear with a same-cycle sample, foreign samples,
    // busy start, stalled result stream.
    stall = 1'b1;
    flux = '{100, 200, 300, 450, 500, 50, 399, 400};
    run_frame(16'd400, 8'd3, 1, 3, 3'd2, 3'd4, 1'b1, 1'b1);

    // Frame 3: zero passes run as one; empty clear range (lo > hi).
    stall = 1'b0;
    flux = '{99, 100, 101, 0, 7, 65535, 3, 200};
    run_frame(16'd100, 8'd0, 0, 0, 3'd5, 3'd3, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule